// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Refresh

This block is a watchdog counter for a small 8-bit microcontroller subsystem. Software programs an 8-bit reload register over a simple strobe bus and starts the watchdog with a start bit. Once started, a 15-bit counter counts up at a divided clock rate. When it rolls over from all ones, the block raises a reset request for one cycle and reloads itself. The reload register's top bit adds a divide-by-16 stage after the fixed divide-by-2 stage. Its lower seven bits set the counter's upper seven bits on every reload.

Software restarts the count by writing the control address twice. The first write sets the arm bit and the next bus access sets the fire bit. Any other bus access in between, whether a read or a write to either address, cancels the arm step. Idle cycles with no access do not cancel it. A refresh loads the reload value into the counter's high part, clears the low byte, and restarts the prescaler from zero.

Top module: `watchdog_reload`

## Requirements
- R1: After reset, reading address 0 returns 0x00, reading address 1 returns 0x00, and `wdt_rst_req` is low.
- R2: A write to address 0 stores the reload byte. A read of address 0 returns that byte, whether or not the watchdog has been started.
- R3: Before the start bit (bit 2 of a write to address 1) has been written, the counter does not advance and no reset request is raised.
- R4: Once started, the watchdog keeps running until reset. A later write to address 1 with bit 2 clear does not stop it, and bit 7 of an address 1 read stays 1.
- R5: A refresh loads the reload byte's bits 6..0 into counter bits 14..8 and clears bits 7..0. Bits 6..0 of an address 1 read show counter bits 14..8.
- R6: A write to address 1 with the fire bit (bit 1) set causes a refresh only if the previous bus access was a write to address 1 with the arm bit (bit 0) set and bit 1 clear. A fire write without that arm step has no effect.
- R7: Any read, or any write other than an arming write, that falls between the arm write and the fire write cancels the arm step, so the fire write then has no effect.
- R8: With reload bit 7 clear, the counter advances once every 2 clocks. The reset request appears 2*(32768 - V*256) clocks after the refresh write, where V is reload bits 6..0.
- R9: With reload bit 7 set, the counter advances once every 32 clocks. The reset request appears 32*(32768 - V*256) clocks after the refresh write.
- R10: The reset request lasts exactly one clock. On the rollover the counter reloads itself, so with no further refresh, requests repeat at the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe (counts as an access) |
| bus_addr | input | 1 | 0 = reload register, 1 = control / counter view |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| wdt_rst_req | output | 1 | One-cycle reset request on counter rollover |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that the reload register is not written in the same cycle as a refresh, because a refresh is itself a write to the other address. The bench drives each access for exactly one clock, with at least one idle cycle between accesses, so these conditions always hold. The bench predicts each reset-request cycle from the refresh-write cycle and the reload byte. Any extra, early, late or missing pulse therefore shows up as a mismatch in the scoreboard.

// File: rtl/wdt_pkg.sv
// Package: shared constants for the watchdog block.
// Assumes an 8-bit data bus and a 1-bit register address.
package wdt_pkg;
    localparam int DATA_W = 8;
    localparam int REL_W  = DATA_W - 1;

    localparam logic ADDR_RELOAD = 1'b0;
    localparam logic ADDR_CTRL   = 1'b1;

    localparam int CTRL_ARM   = 0;
    localparam int CTRL_FIRE  = 1;
    localparam int CTRL_START = 2;

    localparam int RELOAD_SLOW_BIT = DATA_W - 1;

    typedef struct packed {
        logic       slow_sel;
        logic [REL_W-1:0] hi_val;
    } reload_t;
endpackage

// File: rtl/wdt_bus_regs.sv
// Module: bus-facing registers of the watchdog.
// Holds the reload byte, the sticky run flag and the two-step refresh
// qualifier. Assumes single-cycle strobes and never both strobes at once.
module wdt_bus_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output reload_t           reload_q,
    output logic              running,
    output logic              armed,
    output logic              refresh
);
    logic ctrl_wr;
    logic reload_wr;
    logic arm_wr;

    // Decode the write targets and the qualified refresh.
    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == ADDR_CTRL);
        reload_wr = bus_wr && (bus_addr == ADDR_RELOAD);
        arm_wr    = ctrl_wr && bus_wdata[CTRL_ARM] && !bus_wdata[CTRL_FIRE];
        refresh   = ctrl_wr && bus_wdata[CTRL_FIRE] && armed;
    end

    // Reload register: writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (reload_wr) begin
            reload_q <= reload_t'(bus_wdata);
        end
    end

    // Run flag: set by the start bit, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (ctrl_wr && bus_wdata[CTRL_START]) begin
            running <= 1'b1;
        end
    end

    // Arm step: set by an arming write, dropped by any other access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (bus_wr || bus_rd) begin
            armed <= arm_wr;
        end
    end
endmodule

// File: rtl/wdt_prescaler.sv
// Module: clock-enable prescaler for the watchdog counter.
// A divide-by-2 stage always runs while enabled. An optional 2**SLOW_W stage
// follows it and is selected by slow_sel. clr restarts both stages at zero.
module wdt_prescaler #(
    parameter int SLOW_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic slow_sel,
    output logic tick
);
    logic fast_q;
    logic fast_tick;
    logic slow_tick;

    assign fast_tick = run && fast_q;

    // Divide-by-2 stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fast_q <= 1'b0;
        end else if (run) begin
            fast_q <= !fast_q;
        end
    end

    generate
        if (SLOW_W > 0) begin : g_slow
            logic [SLOW_W-1:0] slow_q;

            // Extra divider stepped by the fast tick.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    slow_q <= '0;
                end else if (fast_tick) begin
                    slow_q <= slow_q + 1'b1;
                end
            end

            assign slow_tick = fast_tick && (&slow_q);
        end else begin : g_noslow
            assign slow_tick = fast_tick;
        end
    endgenerate

    // Select the counting rate.
    always_comb begin
        tick = slow_sel ? slow_tick : fast_tick;
    end
endmodule

// File: rtl/wdt_counter.sv
// Module: up-counter of the watchdog with reload and rollover pulse.
// On a refresh, or on rollover from all ones, the high part takes load_hi and
// the low part clears. A refresh has priority over a coincident rollover.
module wdt_counter #(
    parameter int HI_W  = 7,
    parameter int LOW_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  refresh,
    input  logic [HI_W-1:0]       load_hi,
    output logic [HI_W+LOW_W-1:0] cnt,
    output logic                  wrap_pulse
);
    localparam int CNT_W = HI_W + LOW_W;

    logic [CNT_W-1:0] load_val;
    logic             at_max;

    // Reload value and terminal-count decode.
    always_comb begin
        load_val = {load_hi, {LOW_W{1'b0}}};
        at_max   = &cnt;
    end

    // Count, reload and register the rollover pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= 1'b0;
            if (refresh) begin
                cnt <= load_val;
            end else if (tick) begin
                if (at_max) begin
                    cnt        <= load_val;
                    wrap_pulse <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/watchdog_reload.sv
// Module: top of the watchdog with reload register and two-step refresh.
// Address 0 reads back the reload byte. Address 1 reads {running, cnt high}.
// Assumes the bus strobes last one cycle each and never overlap.
module watchdog_reload
    import wdt_pkg::*;
#(
    parameter int LOW_W  = 8,
    parameter int SLOW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_req
);
    localparam int CNT_W = REL_W + LOW_W;

    reload_t          reload_q;
    logic             running;
    logic             armed;
    logic             refresh;
    logic             tick;
    logic [CNT_W-1:0] cnt;

    wdt_bus_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .reload_q (reload_q),
        .running  (running),
        .armed    (armed),
        .refresh  (refresh)
    );

    wdt_prescaler #(.SLOW_W(SLOW_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .clr     (refresh),
        .slow_sel(reload_q.slow_sel),
        .tick    (tick)
    );

    wdt_counter #(.HI_W(REL_W), .LOW_W(LOW_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .refresh   (refresh),
        .load_hi   (reload_q.hi_val),
        .cnt       (cnt),
        .wrap_pulse(wdt_rst_req)
    );

    // Read-data multiplexer.
    always_comb begin
        if (bus_addr == ADDR_RELOAD) begin
            bus_rdata = reload_q;
        end else begin
            bus_rdata = {running, cnt[CNT_W-1:LOW_W]};
        end
    end
endmodule

// File: rtl/wdt_checker.sv
// Module: assertion checker bound to the watchdog top.
// Assumes single-cycle, non-overlapping bus strobes.
module wdt_checker #(
    parameter int HI_W  = 7,
    parameter int LOW_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rst_req,
    input logic                  running,
    input logic                  refresh,
    input logic [HI_W+LOW_W-1:0] cnt,
    input logic [HI_W:0]         reload
);
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !refresh) |=> $stable(cnt));

    p_run_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    p_refresh_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (cnt == {$past(reload[HI_W-1:0]), {LOW_W{1'b0}}}));

    p_req_after_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (&$past(cnt)));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

bind watchdog_reload wdt_checker #(.HI_W(wdt_pkg::REL_W), .LOW_W(LOW_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_req(wdt_rst_req),
    .running(running),
    .refresh(refresh),
    .cnt    (cnt),
    .reload (reload_q)
);

// File: tb/sim_watchdog_reload.sv
module sim_watchdog_reload;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_q[$];
    logic prev_req = 1'b0;

    watchdog_reload u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_req(wdt_rst_req)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int period(input logic [7:0] r);
        return (r[7] ? 32 : 2) * (32768 - int'(r[6:0]) * 256);
    endfunction

    // Monitor: pop the scoreboard on each reset request.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wdt_rst_req) begin
                check(!prev_req, "R10 pulse width", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8/R9 unexpected request", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R8/R9/R10 request cycle", cyc, e);
                end
            end
            prev_req <= wdt_rst_req;
        end else begin
            prev_req <= 1'b0;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d, output int c);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        c = cyc;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Driver: program, start, refresh; returns the refresh cycle.
    task automatic start_refresh(input logic [7:0] r, output int ce);
        int c;
        bus_write(1'b0, r, c);
        bus_write(1'b1, 8'h05, c);
        bus_write(1'b1, 8'h02, ce);
    endtask

    task automatic expect_empty(input string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        logic [7:0] d;
        int c, ce, cr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(1'b0, d); check(d == 8'h00, "R1 reload after reset", d, 0);
        bus_read(1'b1, d); check(d == 8'h00, "R1 ctrl after reset", d, 0);
        check(wdt_rst_req == 1'b0, "R1 request low", wdt_rst_req, 0);

        // R2 readback before start; R5 refresh load; R3 no counting
        bus_write(1'b0, 8'h55, c);
        bus_read(1'b0, d); check(d == 8'h55, "R2 readback idle", d, 8'h55);
        bus_write(1'b1, 8'h01, c);
        bus_write(1'b1, 8'h02, c);
        bus_read(1'b1, d); check(d == 8'h55, "R5 high part loaded", d, 8'h55);
        repeat (2000) @(negedge clk);
        bus_read(1'b1, d); check(d == 8'h55, "R3 no count before start", d, 8'h55);
        bus_write(1'b1, 8'h04, c);
        bus_write(1'b0, 8'h3C, c);
        bus_read(1'b0, d); check(d == 8'h3C, "R2 readback running", d, 8'h3C);
        bus_read(1'b1, d); check(d[7] == 1'b1, "R4 running flag", d[7], 1);
        expect_empty("R3 no request");
        do_reset();

        // R8, R10: fast rate, two periods
        start_refresh(8'h7F, ce);
        exp_q.push_back(ce + period(8'h7F));
        exp_q.push_back(ce + 2 * period(8'h7F));
        wait_until(ce + 2 * period(8'h7F) + 6);
        expect_empty("R10 repeat missing");
        do_reset();

        // R8: other reload value
        start_refresh(8'h7E, ce);
        exp_q.push_back(ce + period(8'h7E));
        wait_until(ce + period(8'h7E) + 6);
        expect_empty("R8 request missing");
        do_reset();

        // R9: slow prescaler
        start_refresh(8'hFF, ce);
        exp_q.push_back(ce + period(8'hFF));
        exp_q.push_back(ce + 2 * period(8'hFF));
        wait_until(ce + 2 * period(8'hFF) + 6);
        expect_empty("R9 request missing");
        do_reset();

        // R6, R7: failed refresh attempts must not move the request
        start_refresh(8'h7F, ce);
        exp_q.push_back(ce + 512);
        wait_until(ce + 100);
        bus_write(1'b1, 8'h02, c);
        wait_until(ce + 200);
        bus_write(1'b1, 8'h01, c);
        bus_read(1'b0, d);
        bus_write(1'b1, 8'h02, c);
        wait_until(ce + 300);
        bus_write(1'b1, 8'h01, c);
        bus_write(1'b0, 8'h7F, c);
        bus_write(1'b1, 8'h02, c);
        wait_until(ce + 600);
        expect_empty("R6/R7 request missing");
        bus_write(1'b1, 8'h01, c);
        bus_write(1'b1, 8'h02, cr);
        exp_q.push_back(cr + 512);
        wait_until(cr + 520);
        expect_empty("R6 valid refresh");
        do_reset();

        // R4: start cannot be cleared
        start_refresh(8'h7F, ce);
        exp_q.push_back(ce + 512);
        wait_until(ce + 100);
        bus_write(1'b1, 8'h00, c);
        bus_read(1'b1, d); check(d[7] == 1'b1, "R4 still running", d[7], 1);
        wait_until(ce + 520);
        expect_empty("R4 request missing");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule